// File: doc/BRIEF.md
# Serial EEPROM Word Read Master

This block fetches one 16-bit word from a small three-wire serial EEPROM organised as 16-bit words. The host gives a one-cycle `start` strobe together with a word address and a size select. The block then runs the whole pin sequence on its own. It raises select and gives one idle clock pulse. It shifts out a start bit, the read opcode and the address. It clocks in sixteen data bits, drops select and gives one trailing clock pulse. When the word is ready it reports a one-cycle `done` pulse.

Two device sizes are supported. The smaller one takes a 6-bit address and the larger one an 8-bit address, selected by `addrBig` when the read starts. Every pin change is followed by `SETTLE_CLKS` system clocks before the next change. That count is also the high time and the low time of the serial clock.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset `eeCs`, `eeSclk`, `eeMosi`, `busy`, `done` and `rdData` are all 0.
- R2: A `start` pulse while idle sets `busy` on the next cycle and clears `rdData` to 0. `addr` and `addrBig` are captured at that edge, so later changes to them have no effect on the read.
- R3: After `eeCs` rises, exactly one full `eeSclk` pulse (high, then low) is given with `eeMosi` at 0, before the first command bit.
- R4: The bits shifted out are 1, 1, 0 (start bit, then the two-bit read opcode 10), followed by the address MSB first. The address is 8 bits when `addrBig`=1. It is 6 bits taken from `addr[5:0]` when `addrBig`=0, and `addr[7:6]` are then ignored.
- R5: `eeMosi` only changes while `eeSclk` is low. Each bit is placed on `eeMosi` before its clock pulse.
- R6: No two of `eeCs`, `eeSclk` and `eeMosi` change in the same cycle. Any two pin changes are at least `SETTLE_CLKS` cycles apart, and every `eeSclk` high phase lasts exactly `SETTLE_CLKS` cycles.
- R7: During the data phase `eeMosi` is held at 0 while exactly 16 clock pulses are given.
- R8: Each data bit is sampled after its pulse has fallen. The bits are assembled MSB first, so the device's leading dummy 0 is never taken in and `rdData` equals the stored word.
- R9: After the 16th bit, `eeCs` falls and one more `eeSclk` pulse follows. `done` is then high for exactly one cycle, in the first cycle with `busy` low. `busy` lasts `SETTLE_CLKS*(48+3*aw)` cycles, where aw is the address width (6 or 8).
- R10: A `start` while `busy` is ignored: the running read is not disturbed and no second read follows. `rdData` holds the word until the next read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a read |
| addr | input | ADDR_W_LARGE | Word address, captured at start |
| addrBig | input | 1 | 1: 8-bit address device, 0: 6-bit address device |
| busy | output | 1 | High while a read is in progress |
| done | output | 1 | One-cycle pulse when the word is valid |
| rdData | output | DATA_W | Assembled read word |
| eeCs | output | 1 | Device select, active high |
| eeSclk | output | 1 | Serial clock to the device |
| eeMosi | output | 1 | Serial data to the device |
| eeMiso | input | 1 | Serial data from the device |

## Verification
A wrong sequencer state or bit count shows at once as a misframed transfer. The device model sees the wrong number of leading zeros, a wrong opcode or address, or more or fewer than 16 data pulses. `busy` then also ends on a different cycle from `SETTLE_CLKS*(48+3*aw)`. A wrong shift or sample order shows only at `done`, as a word that differs from the stored one. Timing faults in the settle counter are caught on the pin edge where they happen, by the pin-spacing checks.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  localparam int          CMD_W    = 3;
  localparam logic [2:0]  CMD_BITS = 3'b110;   // start bit, then read opcode

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CS_ON,
    ST_PRE_HI,
    ST_PRE_LO,
    ST_BIT_SET,
    ST_BIT_HI,
    ST_BIT_LO,
    ST_DO_ZERO,
    ST_RD_HI,
    ST_RD_LO,
    ST_CS_OFF,
    ST_POST_HI,
    ST_POST_LO
  } seqState_t;

  typedef struct packed {
    logic load;       // capture address, clear read word
    logic shiftCmd;   // advance the outgoing bit
    logic sampleBit;  // take in one data bit
    logic driveBit;   // outgoing bit is on the data pin next cycle
  } dpCtl_t;

endpackage

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
  import eeprom_rd_pkg::*;
#(
  parameter int SETTLE_CLKS  = 2,
  parameter int ADDR_W_SMALL = 6,
  parameter int ADDR_W_LARGE = 8,
  parameter int DATA_W       = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   addrBig,
  output logic   busy,
  output logic   done,
  output logic   eeCs,
  output logic   eeSclk,
  output dpCtl_t ctl
);

  localparam int CNT_W    = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
  localparam int TX_SMALL = CMD_W + ADDR_W_SMALL;
  localparam int TX_LARGE = CMD_W + ADDR_W_LARGE;
  localparam int MAX_BITS = (TX_LARGE > DATA_W) ? TX_LARGE : DATA_W;
  localparam int BIT_W    = $clog2(MAX_BITS + 1);

  seqState_t        state, stateD;
  logic [CNT_W-1:0] settleCnt;
  logic [BIT_W-1:0] bitCnt, bitCntD;
  logic             bigQ;
  logic             stepDone, lastTx, lastRx;

  assign stepDone = (settleCnt == CNT_W'(SETTLE_CLKS - 1));
  assign lastTx   = bigQ ? (bitCnt == BIT_W'(TX_LARGE - 1))
                         : (bitCnt == BIT_W'(TX_SMALL - 1));
  assign lastRx   = (bitCnt == BIT_W'(DATA_W - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stateD  = state;
    bitCntD = bitCnt;
    if (state == ST_IDLE) begin
      if (start) begin
        stateD  = ST_CS_ON;
        bitCntD = '0;
      end
    end else if (stepDone) begin
      unique case (state)
        ST_CS_ON:   stateD = ST_PRE_HI;
        ST_PRE_HI:  stateD = ST_PRE_LO;
        ST_PRE_LO:  stateD = ST_BIT_SET;
        ST_BIT_SET: stateD = ST_BIT_HI;
        ST_BIT_HI:  stateD = ST_BIT_LO;
        ST_BIT_LO: begin
          if (lastTx) begin
            stateD  = ST_DO_ZERO;
            bitCntD = '0;
          end else begin
            stateD  = ST_BIT_SET;
            bitCntD = bitCnt + 1'b1;
          end
        end
        ST_DO_ZERO: stateD = ST_RD_HI;
        ST_RD_HI:   stateD = ST_RD_LO;
        ST_RD_LO: begin
          stateD  = lastRx ? ST_CS_OFF : ST_RD_HI;
          bitCntD = bitCnt + 1'b1;
        end
        ST_CS_OFF:  stateD = ST_POST_HI;
        ST_POST_HI: stateD = ST_POST_LO;
        ST_POST_LO: stateD = ST_IDLE;
        default:    stateD = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load      = (state == ST_IDLE) && start;
    ctl.shiftCmd  = (state == ST_BIT_LO) && stepDone;
    ctl.sampleBit = (state == ST_RD_LO) && stepDone;
    ctl.driveBit  = (stateD inside {ST_BIT_SET, ST_BIT_HI, ST_BIT_LO});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      bitCnt    <= '0;
      bigQ      <= 1'b0;
      eeCs      <= 1'b0;
      eeSclk    <= 1'b0;
      done      <= 1'b0;
    end else begin
      state  <= stateD;
      bitCnt <= bitCntD;
      if (state == ST_IDLE || stepDone) settleCnt <= '0;
      else                              settleCnt <= settleCnt + 1'b1;
      if (ctl.load) bigQ <= addrBig;
      eeCs   <= (stateD inside {ST_CS_ON, ST_PRE_HI, ST_PRE_LO, ST_BIT_SET,
                                ST_BIT_HI, ST_BIT_LO, ST_DO_ZERO, ST_RD_HI,
                                ST_RD_LO});
      eeSclk <= (stateD inside {ST_PRE_HI, ST_BIT_HI, ST_RD_HI, ST_POST_HI});
      done   <= (state == ST_POST_LO) && stepDone;
    end
  end

endmodule

// File: rtl/eeprom_rd_dp.sv
module eeprom_rd_dp
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W_SMALL = 6,
  parameter int ADDR_W_LARGE = 8,
  parameter int DATA_W       = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [ADDR_W_LARGE-1:0] addr,
  input  logic                    addrBig,
  input  logic                    eeMiso,
  output logic                    eeMosi,
  output logic [DATA_W-1:0]       rdData
);

  localparam int SH_W  = CMD_W + ADDR_W_LARGE;
  localparam int PAD_W = ADDR_W_LARGE - ADDR_W_SMALL;

  logic [SH_W-1:0]   txShift, txLoad;
  logic [DATA_W-1:0] rxShift;
  logic              mosiQ;

  // Left-align the outgoing bits so the MSB always leaves first.
  generate
    if (PAD_W > 0) begin : g_two_sizes
      assign txLoad = addrBig ? {CMD_BITS, addr}
                              : {CMD_BITS, addr[ADDR_W_SMALL-1:0], {PAD_W{1'b0}}};
    end else begin : g_one_size
      assign txLoad = {CMD_BITS, addr};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      mosiQ   <= 1'b0;
    end else if (ctl.load) begin
      txShift <= txLoad;
      rxShift <= '0;
      mosiQ   <= 1'b0;
    end else begin
      if (ctl.shiftCmd) txShift <= {txShift[SH_W-2:0], 1'b0};
      mosiQ <= ctl.driveBit & (ctl.shiftCmd ? txShift[SH_W-2] : txShift[SH_W-1]);
      if (ctl.sampleBit) rxShift <= {rxShift[DATA_W-2:0], eeMiso};
    end
  end

  assign eeMosi = mosiQ;
  assign rdData = rxShift;

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eeprom_rd_pkg::*;
#(
  parameter int SETTLE_CLKS  = 2,
  parameter int ADDR_W_SMALL = 6,
  parameter int ADDR_W_LARGE = 8,
  parameter int DATA_W       = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [ADDR_W_LARGE-1:0] addr,
  input  logic                    addrBig,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       rdData,
  output logic                    eeCs,
  output logic                    eeSclk,
  output logic                    eeMosi,
  input  logic                    eeMiso
);

  dpCtl_t ctl;

  eeprom_rd_ctrl #(
    .SETTLE_CLKS (SETTLE_CLKS),
    .ADDR_W_SMALL(ADDR_W_SMALL),
    .ADDR_W_LARGE(ADDR_W_LARGE),
    .DATA_W      (DATA_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .addrBig(addrBig),
    .busy   (busy),
    .done   (done),
    .eeCs   (eeCs),
    .eeSclk (eeSclk),
    .ctl    (ctl)
  );

  eeprom_rd_dp #(
    .ADDR_W_SMALL(ADDR_W_SMALL),
    .ADDR_W_LARGE(ADDR_W_LARGE),
    .DATA_W      (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .addr   (addr),
    .addrBig(addrBig),
    .eeMiso (eeMiso),
    .eeMosi (eeMosi),
    .rdData (rdData)
  );

endmodule

// File: rtl/eeprom_word_reader_chk.sv
module eeprom_word_reader_chk #(
  parameter int SETTLE_CLKS = 2,
  parameter int DATA_W      = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdData,
  input logic              eeCs,
  input logic              eeSclk,
  input logic              eeMosi
);

  logic prevCs, prevSclk, prevMosi, pinChange;
  int   ageQ;   // cycles since the last pin change, saturating

  assign pinChange = (eeCs ^ prevCs) | (eeSclk ^ prevSclk) | (eeMosi ^ prevMosi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs   <= 1'b0;
      prevSclk <= 1'b0;
      prevMosi <= 1'b0;
      ageQ     <= SETTLE_CLKS;
    end else begin
      prevCs   <= eeCs;
      prevSclk <= eeSclk;
      prevMosi <= eeMosi;
      if (pinChange)                ageQ <= 1;
      else if (ageQ < SETTLE_CLKS)  ageQ <= ageQ + 1;
    end
  end

  a_r1_idle_pins_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!eeCs && !eeSclk && !eeMosi));

  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (rdData == '0));

  a_r3_select_before_clock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> (!eeSclk && !eeMosi));

  a_r5_mosi_steady_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    eeSclk |-> $stable(eeMosi));

  a_r6_one_pin_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    $countones({eeCs ^ $past(eeCs), eeSclk ^ $past(eeSclk), eeMosi ^ $past(eeMosi)}) <= 1);

  a_r6_settle_spacing: assert property (@(posedge clk) disable iff (!rstN)
    pinChange |-> (ageQ >= SETTLE_CLKS));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_when_released: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !eeCs && !eeSclk));

endmodule

bind eeprom_word_reader eeprom_word_reader_chk #(
  .SETTLE_CLKS(SETTLE_CLKS),
  .DATA_W     (DATA_W)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .busy  (busy),
  .done  (done),
  .rdData(rdData),
  .eeCs  (eeCs),
  .eeSclk(eeSclk),
  .eeMosi(eeMosi)
);

// File: tb/eeprom_word_reader_bench.sv
`timescale 1ns/1ps
module eeprom_word_reader_bench;

  localparam int SETTLE = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        addrBig = 1'b0;
  logic        busy, done, eeCs, eeSclk, eeMosi;
  logic        eeMiso = 1'b0;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // device model state
  int         devPhase, leadZeros, opCnt, aCnt, dIdx, doNonZero, extraPulses, postPulses, curAw;
  logic [1:0] opv;
  logic [7:0] devAddr;
  int         hiRun = 0;
  int         widthErr = 0;

  always #2.5 clk = ~clk;

  eeprom_word_reader #(.SETTLE_CLKS(SETTLE)) u_eeprom_word_reader (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr), .addrBig(addrBig),
    .busy(busy), .done(done), .rdData(rdData),
    .eeCs(eeCs), .eeSclk(eeSclk), .eeMosi(eeMosi), .eeMiso(eeMiso)
  );

  function automatic logic [15:0] memWord(input logic [7:0] a);
    memWord = {a ^ 8'hA5, ~a} ^ 16'h8001;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  // Serial EEPROM model: reacts on rising serial clock edges.
  initial begin
    forever begin
      @(posedge eeSclk);
      if (!eeCs) postPulses++;
      else begin
        case (devPhase)
          0: if (eeMosi) devPhase = 1; else leadZeros++;
          1: begin
            opv = {opv[0], eeMosi};
            opCnt++;
            if (opCnt == 2) devPhase = 2;
          end
          2: begin
            devAddr = {devAddr[6:0], eeMosi};
            aCnt++;
            if (aCnt == curAw) begin
              eeMiso   = 1'b0;   // dummy zero
              devPhase = 3;
            end
          end
          default: begin
            if (eeMosi) doNonZero++;
            if (dIdx < 16) begin
              eeMiso = memWord(devAddr)[15 - dIdx];
              dIdx++;
            end else extraPulses++;
          end
        endcase
      end
    end
  end

  // R6: serial clock high phase width
  initial begin
    forever begin
      @(negedge clk);
      if (eeSclk) hiRun++;
      else if (hiRun != 0) begin
        if (hiRun != SETTLE) widthErr++;
        hiRun = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic doRead(input logic [7:0] a, input logic big, input bit poke);
    int         aw, cnt, expCycles;
    logic [7:0] effA;
    logic [15:0] expW;
    aw        = big ? 8 : 6;
    effA      = big ? a : {2'b00, a[5:0]};
    expW      = memWord(effA);
    expCycles = SETTLE * (48 + 3 * aw);
    devPhase = 0; leadZeros = 0; opCnt = 0; aCnt = 0; dIdx = 0; doNonZero = 0;
    extraPulses = 0; postPulses = 0; opv = 2'b00; devAddr = 8'h00; curAw = aw;
    @(negedge clk);
    start = 1'b1; addr = a; addrBig = big;
    @(negedge clk);
    start = 1'b0; addr = 8'($urandom); addrBig = 1'($urandom);
    check("R2 busy after start", {31'd0, busy}, 32'd1);
    check("R2 rdData cleared", {16'd0, rdData}, 32'd0);
    cnt = 1;
    while (1) begin
      @(negedge clk);
      start = 1'b0;
      if (!busy) break;
      cnt++;
      if (cnt > 20000) begin
        check("watchdog read", 32'd0, 32'd1);
        break;
      end
      if (poke && cnt == 20) begin
        start = 1'b1; addr = ~a; addrBig = ~big;
      end
    end
    check("R9 busy length", cnt, expCycles);
    check("R9 done with busy low", {31'd0, done}, 32'd1);
    check("R9 select low at done", {31'd0, eeCs}, 32'd0);
    check("R3 one idle pulse", leadZeros, 32'd1);
    check("R4 opcode", {30'd0, opv}, 32'd2);
    check("R4 address", {24'd0, devAddr}, {24'd0, effA});
    check("R7 mosi low in data", doNonZero, 32'd0);
    check("R7 data pulse count", dIdx + extraPulses, 32'd16);
    check("R8 read word", {16'd0, rdData}, {16'd0, expW});
    check("R9 trailing pulse", postPulses, 32'd1);
    @(negedge clk);
    check("R9 done one cycle", {31'd0, done}, 32'd0);
    repeat (4) @(negedge clk);
    check("R10 no second read", {31'd0, busy}, 32'd0);
    check("R10 word held", {16'd0, rdData}, {16'd0, expW});
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check("R1 cs", {31'd0, eeCs}, 32'd0);
    check("R1 sclk", {31'd0, eeSclk}, 32'd0);
    check("R1 mosi", {31'd0, eeMosi}, 32'd0);
    check("R1 busy/done", {30'd0, busy, done}, 32'd0);
    check("R1 rdData", {16'd0, rdData}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    doRead(8'h00, 1'b0, 0);
    doRead(8'h3F, 1'b0, 0);
    doRead(8'hFF, 1'b0, 0);   // R4: upper bits ignored for the small device
    doRead(8'hFF, 1'b1, 0);
    doRead(8'h80, 1'b1, 0);
    doRead(8'h01, 1'b1, 1);   // R10: start while busy
    doRead(8'h2A, 1'b0, 1);
    for (int i = 0; i < 20; i++) doRead(8'($urandom), 1'($urandom), 1'($urandom));
    check("R6 sclk high width", widthErr, 32'd0);
    finishRun();
  end

endmodule